// File: doc/BRIEF.md
# Cascaded Integrator-Comb Decimator

This block lowers the sample rate of a signed sample stream by an integer factor R without using any multiplier or coefficient memory. A chain of N accumulators runs at the input rate, updating only when an input sample is accepted. A phase counter passes one accumulator result in every R accepted samples to a chain of N differencing stages. Each differencing stage subtracts its own input from M decimated samples earlier, so it does its work only at the reduced rate. The result is a linear-phase low-pass response equal to N cascaded length-RM box-car sums, decimated by R.

Every register is sized for the worst-case gain (RM)^N. The datapath width is the input width plus the number of bits needed to hold (RM)^N. Accumulators are allowed to wrap in two's complement, and the differencing stages recover the exact result. The block sits after a fast front end, for example a mixer output. It is followed by a slower droop-correction filter that is not part of this block.

Top module: `cic_decim`

## Requirements
- R1: `out_valid` goes high for exactly one clock cycle once for every R accepted input samples (inputs with `in_valid` high), and never on two consecutive cycles when R > 1.
- R2: Cycles with `in_valid` low change no state. Inserting idle cycles between samples leaves the output sequence unchanged.
- R3: A constant input x settles to an output of exactly x·(RM)^N, which is x·2401 in the default configuration N=4, R=7, M=1.
- R4: Let f[m] be the input sequence (zero before the first sample) passed N times through a sum of the last R·M samples. Output number k (counted from 0) equals f[(k+1)·R−1−N].
- R5: The output strobe for a group appears N clock edges after the edge that accepted the group's R-th input sample.
- R6: The output is `BIN + ceil(log2((RM)^N))` bits wide (24 in the default configuration) and loses no bits. Full-scale input −2^(BIN−1) settles to −2048·2401 and +2^(BIN−1)−1 settles to 2047·2401.
- R7: A synchronous active-high reset clears the accumulators, the comb delay lines, the phase counter and the outputs. After reset, `out_valid` and `out_data` are 0, and a new stream is processed as if from power-up.
- R8: M may be 1 or 2. The comb delay spans M decimated samples.
- R9: `out_data` changes only on a cycle in which `out_valid` is high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | BIN | Signed input sample |
| out_valid | output | 1 | Decimated output strobe, one cycle wide |
| out_data | output | OW | Signed full-precision decimated output |

## Verification
The hardest case to reach is an accumulator that has wrapped many times while the differenced output must still be exact. The stimulus holds the most negative and then the most positive input for many decimation periods, so the fourth accumulator overflows repeatedly. The output is then compared with the expected full-scale products. Sample-rate sensitivity is checked by repeating a random stream with random idle gaps inserted. Every output value is compared with an N-pass moving-sum model, and every strobe is timed from the edge that accepted the last sample of its group.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Bits needed to represent the gain (r*m)**n, rounded up.
  function automatic int growth_bits(input int n, input int r, input int m);
    longint g;
    int     b;
    g = 1;
    for (int i = 0; i < n; i++) g = g * r * m;
    b = 0;
    while ((longint'(1) << b) < g) b++;
    return b;
  endfunction

endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] acc
);

  // Two's-complement wraparound is intended; the combs undo it.
  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= acc + din;
  end

  // R2
  integ_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

endmodule

// File: rtl/cic_downsample.sv
module cic_downsample #(
  parameter int W = 24,
  parameter int R = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] din,
  output logic                dvalid,
  output logic signed [W-1:0] dout
);

  localparam int CW = (R > 1) ? $clog2(R) : 1;

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      dvalid <= 1'b0;
      dout   <= '0;
    end else begin
      dvalid <= 1'b0;
      if (in_valid) begin
        if (phase == CW'(R - 1)) begin
          phase  <= '0;
          dvalid <= 1'b1;
          dout   <= din;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, phase} < (CW+1)'(R));

  // R1
  strobe_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dvalid) |-> $past(in_valid));

endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int W = 24,
  parameter int M = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] din,
  output logic                out_valid,
  output logic signed [W-1:0] dout
);

  logic signed [W-1:0] dly [M];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
      for (int k = 0; k < M; k++) dly[k] <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dout   <= din - dly[M-1];
        dly[0] <= din;
        for (int k = 1; k < M; k++) dly[k] <= dly[k-1];
      end
    end
  end

  // R5
  comb_stage_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  comb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dout));

endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter  int BIN = 12,
  parameter  int N   = 4,
  parameter  int R   = 7,
  parameter  int M   = 1,
  localparam int OW  = BIN + cic_pkg::growth_bits(N, R, M)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [BIN-1:0] in_data,
  output logic                  out_valid,
  output logic signed [OW-1:0]  out_data
);

  // R8: only differential delays of one or two decimated samples are built.
  if (M < 1 || M > 2) begin : g_bad_m
    $error("cic_decim: M must be 1 or 2");
  end

  logic signed [OW-1:0] integ [N+1];
  logic signed [OW-1:0] cdat  [N+1];
  logic                 cval  [N+1];

  assign integ[0] = {{(OW-BIN){in_data[BIN-1]}}, in_data};

  for (genvar i = 0; i < N; i++) begin : g_integ
    cic_integ #(.W(OW)) u_integ (
      .clk (clk),
      .rst (rst),
      .en  (in_valid),
      .din (integ[i]),
      .acc (integ[i+1])
    );
  end

  cic_downsample #(.W(OW), .R(R)) u_down (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .din      (integ[N]),
    .dvalid   (cval[0]),
    .dout     (cdat[0])
  );

  for (genvar j = 0; j < N; j++) begin : g_comb
    cic_comb #(.W(OW), .M(M)) u_comb (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (cval[j]),
      .din       (cdat[j]),
      .out_valid (cval[j+1]),
      .dout      (cdat[j+1])
    );
  end

  assign out_valid = cval[N];
  assign out_data  = cdat[N];

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_data) |-> out_valid);

  if (R > 1) begin : g_gap_chk
    // R1
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
  end

endmodule

// File: tb/cic_decim_tb_top.sv
module cic_decim_tb_top;

  localparam int BIN  = 12;
  localparam int N    = 4;
  localparam int R    = 7;
  localparam int M    = 1;
  localparam int RM   = R * M;
  localparam int OW   = 24;   // 12 input bits + 12 bits for gain 2401
  localparam int MAXS = 400;
  localparam int MAXO = 80;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  in_valid = 1'b0;
  logic signed [BIN-1:0] in_data = '0;
  logic                  out_valid;
  logic signed [OW-1:0]  out_data;

  always #4 clk = ~clk;

  cic_decim #(.BIN(BIN), .N(N), .R(R), .M(M)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int total = 0, bad = 0, pcyc = 0;
  bit finished = 0;
  always @(posedge clk) pcyc <= pcyc + 1;

  longint xs [MAXS];
  int     acc_edge [MAXS];
  int     nx = 0;
  longint got [MAXO];
  int     got_edge [MAXO];
  int     ngot = 0, dbl = 0, hold_bad = 0;
  logic   prev_v = 1'b0;
  logic signed [OW-1:0] prev_d = '0;
  longint ma [MAXS];
  longint mb [MAXS];

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (prev_v) dbl++;
        if (ngot < MAXO) begin
          got[ngot]      = out_data;
          got_edge[ngot] = pcyc;
        end
        ngot++;
      end else if (out_data !== prev_d) begin
        hold_bad++;
      end
    end
    prev_v = out_valid;
    prev_d = out_data;
  end

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nx = 0; ngot = 0; dbl = 0; hold_bad = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    clear_log();
  endtask

  task automatic push(input longint x);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = x[BIN-1:0];
    acc_edge[nx] = pcyc + 1;
    xs[nx] = x;
    nx++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  // Drain, then compare with N passes of a length-RM moving sum.
  task automatic verify(input string req, input bit chk_lat);
    int nexp;
    idle(N + 4);
    for (int i = 0; i < nx; i++) ma[i] = xs[i];
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < nx; m++) begin
        longint s = 0;
        for (int j = 0; j < RM; j++) if (m - j >= 0) s += ma[m-j];
        mb[m] = s;
      end
      for (int m = 0; m < nx; m++) ma[m] = mb[m];
    end
    nexp = nx / R;
    check("R1 strobe count", ngot, nexp);
    check("R1 no back-to-back strobe", dbl, 0);
    check("R9 data held between strobes", hold_bad, 0);
    for (int k = 0; k < ngot && k < MAXO && k < nexp; k++) begin
      int idx = (k + 1) * R - 1 - N;
      check(req, got[k], (idx >= 0) ? ma[idx] : 0);
      if (chk_lat) check("R5 latency", got_edge[k] - acc_edge[(k+1)*R-1], N);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check("R7 out_valid after reset", out_valid, 0);
    check("R7 out_data after reset", out_data, 0);
  endtask

  task automatic t_impulse();
    do_reset();
    push(1000);
    for (int i = 0; i < 48; i++) push(0);
    verify("R4 impulse", 1'b1);
  endtask

  task automatic t_dc();
    do_reset();
    for (int i = 0; i < 70; i++) push(37);
    verify("R4 dc ramp", 1'b1);
    check("R3 dc settles to x*2401", got[9], 37 * 2401);
  endtask

  task automatic t_fullscale();
    do_reset();
    for (int i = 0; i < 84; i++) push(-2048);
    verify("R6 negative full scale", 1'b0);
    check("R6 -2048*2401", got[11], -2048 * 2401);
    do_reset();
    for (int i = 0; i < 84; i++) push(2047);
    verify("R6 positive full scale", 1'b0);
    check("R6 2047*2401", got[11], 2047 * 2401);
  endtask

  task automatic t_stream();
    do_reset();
    for (int i = 0; i < 280; i++) push($signed($urandom_range(0, 4095)) - 2048);
    verify("R4 random stream", 1'b1);
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 140; i++) begin
      push($signed($urandom_range(0, 4095)) - 2048);
      idle($urandom_range(0, 3));
    end
    verify("R2 stream with idle gaps", 1'b1);
  endtask

  task automatic t_reset_mid();
    do_reset();
    for (int i = 0; i < 20; i++) push(1500);
    @(posedge clk); #1;
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    check("R7 out_valid in mid reset", out_valid, 0);
    check("R7 out_data in mid reset", out_data, 0);
    @(posedge clk); #1 rst = 1'b0;
    clear_log();
    push(-300);
    for (int i = 0; i < 34; i++) push(5);
    verify("R7 fresh response after reset", 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_impulse();
    t_dc();
    t_fullscale();
    t_stream();
    t_gaps();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule